// File: doc/BRIEF.md
# Two-wire EEPROM slave protocol engine

This block is the serial side of a 2K x 8 non-volatile memory that answers on a two-wire bus. A system clock oversamples the bus clock and data lines. The block finds the bus start and stop conditions and checks the device code in the first byte. It acknowledges bytes by pulling the data line low, collects an 11-bit word address, and serves byte writes and three kinds of read: current-address, random and sequential. The storage array and the address pointer sit inside the block.

A write is not carried out while bytes are still arriving. The data byte waits in a holding register until the master sends a stop. A self-timed commit then runs for a fixed number of system clocks, and `busy_o` is high for that time. While the commit runs the block ignores the bus entirely.

Top module: `eeprom_twowire_slave`

## Requirements
- R1: After reset the data line is released (`sda_pull_o` = 0) and `busy_o` is 0.
- R2: A first byte whose upper four bits are not 1010 is not acknowledged, and the block ignores every later bit until the next start.
- R3: A first byte of the form 1010 b b b 0 is acknowledged, with the data line held low for the whole high phase of the ninth clock. Its three b bits set address bits 10:8, and the next byte sets bits 7:0 and is also acknowledged.
- R4: In a write, the data byte after the word address is acknowledged. At the stop, `busy_o` goes high for WR_CYCLES clocks and the byte is then stored at that address.
- R5: While `busy_o` is high, start and stop are ignored, a control byte gets no acknowledge, and the data line stays released.
- R6: With `wp_i` high at the stop, the data byte is still acknowledged, but `busy_o` stays low and the stored value is unchanged.
- R7: A random read (write-mode control byte, word address, repeated start, then control byte 1010 x x x 1) returns the addressed byte MSB first. The block changes the data line only while SCL is low.
- R8: A read-mode control byte starts at the internal pointer, which rests one past the last byte accessed. Its three b bits do not move the pointer.
- R9: A master acknowledge (data low on the ninth clock) after a read byte sends the next address. Reads cross block boundaries, and address 0x7FF is followed by 0x000.
- R10: A missing master acknowledge ends a read and releases the line. Nine clocks with SDA left high free a read that is stuck mid-byte.
- R11: A start in the middle of a write discards the held data byte, so no commit follows.
- R12: A second data byte in one write gets no acknowledge and is not stored. Only the first data byte is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| wp_i | input | 1 | Write protect; high blocks the commit |
| sda_pull_o | output | 1 | High drives the open-drain data line low |
| busy_o | output | 1 | High during the self-timed commit |

## Verification
The assertions assume that each bus clock phase lasts several system clocks longer than the two-flop synchronizer. They also assume that the master changes SDA only while SCL is low, apart from start and stop. Under those assumptions, every change of `sda_pull_o` lands in a low SCL phase, and the acknowledge is held for the whole high phase. The bench holds every SCL half period for eight system clocks and waits two further clocks after each falling edge before it moves SDA. The data line is modelled as a wired AND of the master and the block.

// File: rtl/eeprom_twowire_slave.sv
module eeprom_twowire_slave #(
  parameter int ADDR_W    = 11,
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_pull_o,
  output logic busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BLK_W = ADDR_W - 8;
  localparam int WC_W  = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {P_CTRL, P_WADDR, P_WDATA} ph_t;

  logic [2:0] scl_sy, sda_sy;
  logic scl_s, scl_q, sda_s, sda_q;
  logic start_det, stop_det, scl_rise, scl_fall;

  st_t st;
  ph_t ph;
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic [ADDR_W-1:0] ptr, pend_addr;
  logic [7:0] pend_data;
  logic pend, rw;
  logic [WC_W-1:0] wcnt;
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  assign scl_s     = scl_sy[1];
  assign scl_q     = scl_sy[2];
  assign sda_s     = sda_sy[1];
  assign sda_q     = sda_sy[2];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign busy_o    = wcnt != '0;
  assign rd_byte   = mem[ptr];

  always_ff @(posedge clk)
    if (wcnt == WC_W'(1)) mem[pend_addr] <= pend_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= P_CTRL;
      shreg <= '0;
      cnt <= '0;
      ptr <= '0;
      pend_addr <= '0;
      pend_data <= '0;
      pend <= 1'b0;
      rw <= 1'b0;
      wcnt <= '0;
      sda_pull_o <= 1'b0;
    end else if (busy_o) begin
      wcnt <= wcnt - 1'b1;
    end else if (stop_det) begin
      st <= S_IDLE;
      sda_pull_o <= 1'b0;
      pend <= 1'b0;
      if (pend && !wp_i) wcnt <= WC_W'(WR_CYCLES);
    end else if (start_det) begin
      st <= S_RX;
      ph <= P_CTRL;
      cnt <= '0;
      sda_pull_o <= 1'b0;
      pend <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            case (ph)
              P_CTRL:
                if (shreg[7:4] == 4'b1010) begin
                  sda_pull_o <= 1'b1;
                  st <= S_ACK;
                  rw <= shreg[0];
                  ph <= P_WADDR;
                  if (!shreg[0]) ptr[ADDR_W-1:8] <= shreg[BLK_W:1];
                end else begin
                  st <= S_IDLE;
                end
              P_WADDR: begin
                ptr[7:0] <= shreg;
                sda_pull_o <= 1'b1;
                st <= S_ACK;
                ph <= P_WDATA;
              end
              default:
                if (!pend) begin
                  pend <= 1'b1;
                  pend_addr <= ptr;
                  pend_data <= shreg;
                  ptr <= ptr + 1'b1;
                  sda_pull_o <= 1'b1;
                  st <= S_ACK;
                end else begin
                  st <= S_IDLE;
                end
            endcase
          end
        S_ACK:
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st <= S_TX;
              shreg <= rd_byte;
              sda_pull_o <= ~rd_byte[7];
              ptr <= ptr + 1'b1;
            end else begin
              st <= S_RX;
              sda_pull_o <= 1'b0;
            end
          end
        S_TX:
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_pull_o <= 1'b0;
              st <= S_MACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              sda_pull_o <= ~shreg[6];
            end
          end
        S_MACK:
          if (scl_rise && sda_s) begin
            st <= S_IDLE;
          end else if (scl_fall) begin
            cnt <= '0;
            st <= S_TX;
            shreg <= rd_byte;
            sda_pull_o <= ~rd_byte[7];
            ptr <= ptr + 1'b1;
          end
        default: ;
      endcase
    end
  end

  assert_ack_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_ACK |-> sda_pull_o);
  assert_busy_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(busy_o)) |-> $past(stop_det));
  assert_silent_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o);
  assert_wp_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !busy_o && wp_i) |=> !busy_o);
  assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s);
  assert_mack_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_MACK |-> !sda_pull_o);
endmodule

// File: tb/test_eeprom_twowire_slave.sv
module test_eeprom_twowire_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int WRC = 40;
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {11'h000, 8'h3A}, {11'h123, 8'hC5}, {11'h2FF, 8'h81},
    {11'h300, 8'h7E}, {11'h7FF, 8'h5C}, {11'h5AA, 8'h00}};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
  logic pull, busy, sda;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  assign sda = ~(m_low | pull);
  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_twowire_slave #(.WR_CYCLES(WRC)) i_eeprom_twowire_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .wp_i(wp),
    .sda_pull_o(pull), .busy_o(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_low = 1'b0; tick(H); scl = 1'b1; tick(H); m_low = 1'b1; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic m_stop();
    m_low = 1'b1; tick(H); scl = 1'b1; tick(H); m_low = 1'b0; tick(H);
  endtask

  task automatic clk_pulse();
    tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic held);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; clk_pulse();
    end
    m_low = 1'b0; tick(H); scl = 1'b1; tick(2); a1 = sda; tick(H-2); a2 = sda;
    scl = 1'b0; tick(2);
    ack = ~a2;
    held = (a1 == a2);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b, output logic stable_ok);
    logic s1;
    m_low = 1'b0; stable_ok = 1'b1; b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(H); scl = 1'b1; tick(2); s1 = sda; tick(H-2);
      if (sda !== s1) stable_ok = 1'b0;
      b = {b[6:0], s1};
      scl = 1'b0; tick(2);
    end
    m_low = mack; clk_pulse(); m_low = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input logic [10:0] a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic set_ptr(input logic [10:0] a);
    logic k, h;
    m_start(); send_byte(ctl(a, 1'b0), k, h); send_byte(a[7:0], k, h);
  endtask

  task automatic rand_read(input logic [10:0] a, input string req, input logic [7:0] exp);
    logic k, h, st;
    logic [7:0] b;
    set_ptr(a);
    m_start(); send_byte(ctl(a, 1'b1), k, h);
    recv_byte(1'b0, b, st);
    m_stop();
    chk(req, b, exp);
    chk({req, " stable"}, st, 1'b1);
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(H);
  endtask

  task automatic byte_write(input logic [10:0] a, input logic [7:0] d,
                            output logic ka, output logic kb, output logic kc, output logic hl);
    logic h2, h3;
    m_start(); send_byte(ctl(a, 1'b0), ka, hl);
    send_byte(a[7:0], kb, h2); send_byte(d, kc, h3);
    hl = hl & h2 & h3;
    m_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic ka, kb, kc, hl, st;
    logic [7:0] b;
    tick(4);
    chk("R1 reset pull", pull, 1'b0);
    chk("R1 reset busy", busy, 1'b0);
    rst_n = 1'b1; tick(4);

    for (int i = 0; i < NV; i++) begin
      byte_write(VEC[i][18:8], VEC[i][7:0], ka, kb, kc, hl);
      chk("R3 ctrl ack", ka, 1'b1);
      chk("R3 addr ack", kb, 1'b1);
      chk("R3 ack held", hl, 1'b1);
      chk("R4 data ack", kc, 1'b1);
      chk("R4 busy", busy, 1'b1);
      wait_idle();
      rand_read(VEC[i][18:8], "R7 random read", VEC[i][7:0]);
    end

    rand_read(11'h2FF, "R8 setup", 8'h81);
    m_start(); send_byte(8'hA1, ka, hl);
    recv_byte(1'b0, b, st); m_stop();
    chk("R8 current read", b, 8'h7E);
    rand_read(11'h7FF, "R8 setup wrap", 8'h5C);
    m_start(); send_byte(8'hAF, ka, hl);
    recv_byte(1'b0, b, st); m_stop();
    chk("R8 block bits ignored", b, 8'h3A);

    set_ptr(11'h2FF); m_start(); send_byte(ctl(11'h2FF, 1'b1), ka, hl);
    recv_byte(1'b1, b, st); chk("R9 first", b, 8'h81);
    recv_byte(1'b0, b, st); m_stop(); chk("R9 block cross", b, 8'h7E);
    set_ptr(11'h7FF); m_start(); send_byte(ctl(11'h7FF, 1'b1), ka, hl);
    recv_byte(1'b1, b, st); chk("R9 last", b, 8'h5C);
    recv_byte(1'b0, b, st); m_stop(); chk("R9 wrap", b, 8'h3A);

    m_start(); send_byte(8'hB0, ka, hl); chk("R2 bad code nack", ka, 1'b0);
    send_byte(8'hA0, ka, hl); chk("R2 stays idle", ka, 1'b0);
    m_stop();

    byte_write(11'h123, 8'h99, ka, kb, kc, hl);
    m_start(); send_byte(8'hA0, ka, hl);
    chk("R5 busy nack", ka, 1'b0);
    chk("R5 released", pull, 1'b0);
    m_stop(); wait_idle();
    rand_read(11'h123, "R4 committed", 8'h99);

    wp = 1'b1;
    byte_write(11'h5AA, 8'hFF, ka, kb, kc, hl);
    chk("R6 data ack", kc, 1'b1);
    tick(4); chk("R6 no busy", busy, 1'b0);
    wp = 1'b0;
    rand_read(11'h5AA, "R6 unchanged", 8'h00);

    set_ptr(11'h000); send_byte(8'h11, kc, hl);
    m_start(); m_stop(); tick(4);
    chk("R11 no busy", busy, 1'b0);
    rand_read(11'h000, "R11 unchanged", 8'h3A);

    set_ptr(11'h300); send_byte(8'h42, kc, hl);
    chk("R12 first ack", kc, 1'b1);
    send_byte(8'h43, kc, hl);
    chk("R12 second nack", kc, 1'b0);
    m_stop(); wait_idle();
    rand_read(11'h300, "R12 first stored", 8'h42);

    set_ptr(11'h000); m_start(); send_byte(ctl(11'h000, 1'b1), ka, hl);
    m_low = 1'b0; clk_pulse(); tick(H);
    chk("R10 stuck low", pull, 1'b1);
    for (int i = 0; i < 9; i++) clk_pulse();
    tick(H);
    chk("R10 released", pull, 1'b0);
    m_stop();
    rand_read(11'h123, "R10 after recovery", 8'h99);

    summary();
  end
endmodule